// File: doc/BRIEF.md
# Daisy-Chainable Three-Wire Wiper Register

This block is the digital control for a pair of 256-step potentiometer wipers. A host talks to it over three wires: a select line, a serial clock and a serial data input. While the select is high, each rising serial clock edge moves one data bit into a 17-bit frame register. The frame holds both wiper codes and a stack-select bit. The codes the outputs see live in separate active registers. They copy the frame only when the select drops, so the wiper outputs never move while a frame is being shifted.

Bit 0 of the frame is always visible on a cascade output. That output changes only when the frame shifts, and the select line does not affect it. Wiring one device's cascade output to the next device's data input builds a chain that is written with 17 bits per device. Looping the last cascade output back to the first data input lets the host read every frame. After one full lap the frames hold their starting contents, so the next select fall reloads the same values.

The serial pins are asynchronous to the block. A short synchronizer brings them into the system clock domain, and the block detects their edges there. A stacked output presents whichever wiper code the stack-select bit picks.

Top module: `wiper_link`

## Requirements
- R1: After `rst_n` is released, both wiper codes read 8'b1000_0000, `stack_sel` reads 0, and the frame register holds the same values, so `ser_cout` reads 0.
- R2: Frame layout: bit 0 is the stack select, bits 1..8 hold the wiper-1 code with its MSB at bit 1, and bits 9..16 hold the wiper-0 code with its MSB at bit 9. On the wire the order is the stack select, then wiper 1 MSB first, then wiper 0 MSB first. Each new bit enters at bit 16 and the frame moves toward bit 0.
- R3: The active codes and `stack_sel` change only after a select fall that ends a transaction. They hold their values through every clock edge of the shift.
- R4: `ser_cout` always shows frame bit 0. At the start of a transaction that bit is the stack select, and each accepted serial clock rise moves the next bit onto it.
- R5: Serial clock edges while the select is low leave the frame register unchanged.
- R6: If `ser_cout` is fed back to the data input and clocked 17 times per device, the frames return to their starting contents. The following select fall leaves every active value as it was.
- R7: `stack_code` equals the wiper-0 code when `stack_sel` is 0 and the wiper-1 code when it is 1.
- R8: In a chain, the first 17 bits sent land in the device farthest from the host. A chain of N devices takes 17×N clocks per transaction.
- R9: A transaction of any length, including a short one, is loaded as shifted when the select falls. There is no length check.
- R10: A serial clock rise seen in the same synchronized sample as the select fall is ignored. The load uses the frame as it was before that edge.
- R11: A select held high through reset opens no transaction. Clock edges are ignored until the select goes low and rises again, and a select fall in that state loads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset (power-up state) |
| ser_sel | input | 1 | Serial select, high during a transaction |
| ser_clk | input | 1 | Serial clock, data taken on its rising edge |
| ser_din | input | 1 | Serial data input |
| ser_cout | output | 1 | Cascade output, frame bit 0 |
| wiper0_code | output | CODE_W | Active wiper-0 code |
| wiper1_code | output | CODE_W | Active wiper-1 code |
| stack_sel | output | 1 | Active stack-select bit |
| stack_code | output | CODE_W | Wiper code chosen by the stack select |

## Verification
Two functions can fall in the same synchronized sample: the select fall that loads the active registers and a serial clock rise that would shift the frame. The bench provokes this by driving the last clock rise and the select fall on the same system clock edge, so both pass through equal synchronizer depths. It then checks that the active codes match a bench model that skipped the shift, and that `ser_cout` did not advance. An arithmetic sweep writes every wiper-0 code into a two-device chain and checks the cascade stream bit by bit. Circular reads are checked after select-low clock noise.

// File: rtl/wiper_link.sv
module wiper_link #(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_sel,
  input  logic              ser_clk,
  input  logic              ser_din,
  output logic              ser_cout,
  output logic [CODE_W-1:0] wiper0_code,
  output logic [CODE_W-1:0] wiper1_code,
  output logic              stack_sel,
  output logic [CODE_W-1:0] stack_code
);
  localparam int FRAME_W = 2 * CODE_W + 1;
  localparam int W1_LO   = 1;
  localparam int W0_LO   = CODE_W + 1;
  localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

  function automatic logic [CODE_W-1:0] field_get(input logic [FRAME_W-1:0] f, input int lo);
    field_get = '0;
    for (int i = 0; i < CODE_W; i++) field_get[CODE_W-1-i] = f[lo+i];
  endfunction

  function automatic logic [FRAME_W-1:0] frame_put(input logic [CODE_W-1:0] w0,
                                                   input logic [CODE_W-1:0] w1,
                                                   input logic s);
    frame_put    = '0;
    frame_put[0] = s;
    for (int i = 0; i < CODE_W; i++) begin
      frame_put[W1_LO+i] = w1[CODE_W-1-i];
      frame_put[W0_LO+i] = w0[CODE_W-1-i];
    end
  endfunction

  localparam logic [FRAME_W-1:0] POR_FRAME = frame_put(MID_CODE, MID_CODE, 1'b0);

  logic [SYNC_STAGES-1:0] sel_sync, clk_sync, din_sync;
  logic                   sel_q, clk_q, armed;
  logic                   sel_s, clk_s, din_s;
  logic                   sel_rise, sel_fall, clk_rise, shift_en, load_en;
  logic [FRAME_W-1:0]     shift_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_sync <= '1;
      clk_sync <= '1;
      din_sync <= '0;
      sel_q    <= 1'b1;
      clk_q    <= 1'b1;
    end else begin
      sel_sync <= {sel_sync[SYNC_STAGES-2:0], ser_sel};
      clk_sync <= {clk_sync[SYNC_STAGES-2:0], ser_clk};
      din_sync <= {din_sync[SYNC_STAGES-2:0], ser_din};
      sel_q    <= sel_s;
      clk_q    <= clk_s;
    end
  end

  assign sel_s    = sel_sync[SYNC_STAGES-1];
  assign clk_s    = clk_sync[SYNC_STAGES-1];
  assign din_s    = din_sync[SYNC_STAGES-1];
  assign sel_rise = sel_s & ~sel_q;
  assign sel_fall = ~sel_s & sel_q;
  assign clk_rise = clk_s & ~clk_q;
  assign shift_en = sel_s & (armed | sel_rise) & clk_rise;
  assign load_en  = sel_fall & armed;

  always_ff @(posedge clk) begin
    if (!rst_n)        armed <= 1'b0;
    else if (sel_rise) armed <= 1'b1;
    else if (!sel_s)   armed <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        shift_q <= POR_FRAME;
    else if (shift_en) shift_q <= {din_s, shift_q[FRAME_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wiper0_code <= MID_CODE;
      wiper1_code <= MID_CODE;
      stack_sel   <= 1'b0;
    end else if (load_en) begin
      wiper0_code <= field_get(shift_q, W0_LO);
      wiper1_code <= field_get(shift_q, W1_LO);
      stack_sel   <= shift_q[0];
    end
  end

  assign ser_cout   = shift_q[0];
  assign stack_code = stack_sel ? wiper1_code : wiper0_code;
endmodule

// File: rtl/wiper_link_chk.sv
module wiper_link_chk #(
  parameter int CODE_W  = 8,
  parameter int FRAME_W = 17
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sel_s,
  input logic               armed,
  input logic               sel_rise,
  input logic               sel_fall,
  input logic               clk_rise,
  input logic [FRAME_W-1:0] shift_q,
  input logic [CODE_W-1:0]  wiper0_code,
  input logic [CODE_W-1:0]  wiper1_code,
  input logic               stack_sel,
  input logic               ser_cout
);
  // R3
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(wiper0_code) || !$stable(wiper1_code) || !$stable(stack_sel)) |-> $past(sel_fall && armed));

  // R2
  load_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_fall && armed) |=> (wiper0_code[CODE_W-1] == $past(shift_q[CODE_W+1]) &&
                             wiper1_code[CODE_W-1] == $past(shift_q[1]) &&
                             stack_sel == $past(shift_q[0])));

  // R5
  idle_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_s |=> $stable(shift_q));

  // R4
  cout_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_cout) |-> $past(clk_rise && sel_s));

  // R11
  unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !sel_rise) |=> $stable(shift_q));
endmodule

bind wiper_link wiper_link_chk #(.CODE_W(CODE_W), .FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .armed(armed), .sel_rise(sel_rise),
  .sel_fall(sel_fall), .clk_rise(clk_rise), .shift_q(shift_q),
  .wiper0_code(wiper0_code), .wiper1_code(wiper1_code), .stack_sel(stack_sel),
  .ser_cout(ser_cout)
);

// File: tb/test_wiper_link.sv
module test_wiper_link;
  localparam int CW = 8;
  localparam int FW = 2 * CW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_sel = 1'b1;
  logic ser_clk = 1'b0;
  logic din_drv = 1'b0;
  logic fb = 1'b0;
  logic cout_a, cout_b, sel_a, sel_b, din_a;
  logic [CW-1:0] w0_a, w1_a, sc_a, w0_b, w1_b, sc_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [FW-1:0] m_sr [2];
  logic [CW-1:0] m_w0 [2];
  logic [CW-1:0] m_w1 [2];
  logic          m_s  [2];
  logic          rd   [2*FW];

  always #10 clk = ~clk;

  assign din_a = fb ? cout_b : din_drv;

  wiper_link #(.CODE_W(CW), .SYNC_STAGES(2)) i_wiper_link (
    .clk(clk), .rst_n(rst_n), .ser_sel(ser_sel), .ser_clk(ser_clk), .ser_din(din_a),
    .ser_cout(cout_a), .wiper0_code(w0_a), .wiper1_code(w1_a), .stack_sel(sel_a),
    .stack_code(sc_a));

  wiper_link #(.CODE_W(CW), .SYNC_STAGES(2)) i_wiper_link_nxt (
    .clk(clk), .rst_n(rst_n), .ser_sel(ser_sel), .ser_clk(ser_clk), .ser_din(cout_a),
    .ser_cout(cout_b), .wiper0_code(w0_b), .wiper1_code(w1_b), .stack_sel(sel_b),
    .stack_code(sc_b));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] get_code(input logic [FW-1:0] f, input int lo);
    logic [CW-1:0] r = '0;
    for (int i = 0; i < CW; i++) r[CW-1-i] = f[lo+i];
    return r;
  endfunction

  task automatic model_load();
    for (int d = 0; d < 2; d++) begin
      m_w0[d] = get_code(m_sr[d], CW + 1);
      m_w1[d] = get_code(m_sr[d], 1);
      m_s[d]  = m_sr[d][0];
    end
  endtask

  task automatic check_dev(input string tag);
    chk({tag, " w0 a"}, w0_a, m_w0[0]);
    chk({tag, " w1 a"}, w1_a, m_w1[0]);
    chk({tag, " sel a"}, sel_a, m_s[0]);
    chk({tag, " w0 b"}, w0_b, m_w0[1]);
    chk({tag, " w1 b"}, w1_b, m_w1[1]);
    chk({tag, " sel b"}, sel_b, m_s[1]);
    chk("R7 stack a", sc_a, m_s[0] ? m_w1[0] : m_w0[0]);
    chk("R7 stack b", sc_b, m_s[1] ? m_w1[1] : m_w0[1]);
  endtask

  task automatic bit_out(input logic b, input bit upd);
    logic bin, nb;
    din_drv = b;
    bin = fb ? m_sr[1][0] : b;
    repeat (4) @(negedge clk);
    ser_clk = 1'b1;
    if (upd) begin
      nb = m_sr[0][0];
      m_sr[1] = {nb, m_sr[1][FW-1:1]};
      m_sr[0] = {bin, m_sr[0][FW-1:1]};
    end
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
    if (upd) begin
      repeat (2) @(negedge clk);
      chk("R4 cout a", cout_a, m_sr[0][0]);
      chk("R4 cout b", cout_b, m_sr[1][0]);
    end
  endtask

  task automatic sel_hi();
    ser_sel = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic sel_lo();
    ser_sel = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_dev(input logic [CW-1:0] w0, input logic [CW-1:0] w1, input logic s);
    bit_out(s, 1'b1);
    for (int i = CW - 1; i >= 0; i--) bit_out(w1[i], 1'b1);
    for (int i = CW - 1; i >= 0; i--) bit_out(w0[i], 1'b1);
  endtask

  task automatic read_loop(input string tag);
    fb = 1'b1;
    sel_hi();
    for (int k = 0; k < 2 * FW; k++) begin
      rd[k] = cout_b;
      bit_out(1'b0, 1'b1);
    end
    sel_lo();
    fb = 1'b0;
    for (int k = 0; k < FW; k++) begin
      chk({tag, " stream b"}, rd[k], m_sr[1][k]);
      chk({tag, " stream a"}, rd[FW+k], m_sr[0][k]);
    end
    model_load();
    check_dev(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] a0, a1, b0, b1;
    for (int d = 0; d < 2; d++) begin
      m_sr[d] = {1'b0, {(CW-1){1'b0}}, 1'b0, {(CW-1){1'b0}}, 1'b0};
      m_sr[d][CW+1] = 1'b1;
      m_sr[d][1]    = 1'b1;
    end
    model_load();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check_dev("R1 reset");
    chk("R1 cout a", cout_a, 0);
    chk("R1 cout b", cout_b, 0);

    // R11: select held high through reset, clocks must be ignored
    for (int k = 0; k < 3; k++) bit_out(1'b1, 1'b0);
    sel_lo();
    check_dev("R11 no txn");
    chk("R11 cout a", cout_a, 0);

    // R2 R8 sweep: every wiper-0 code over a two-device chain
    for (int c = 0; c < 256; c++) begin
      a0 = CW'(c);
      a1 = CW'(c * 37 + 11);
      b0 = ~CW'(c);
      b1 = CW'(c) ^ 8'h5A;
      sel_hi();
      chk("R4 start a", cout_a, m_sr[0][0]);
      send_dev(b0, b1, c[1]);
      check_dev("R3 mid txn");
      send_dev(a0, a1, c[0]);
      check_dev("R3 before fall");
      sel_lo();
      model_load();
      chk("R2 w0 a", w0_a, a0);
      chk("R2 w1 a", w1_a, a1);
      chk("R8 w0 b", w0_b, b0);
      chk("R8 w1 b", w1_b, b1);
      check_dev("R2 R8 load");
    end

    // R5: clocks with select low, then R6 circular read
    for (int k = 0; k < 5; k++) bit_out(1'b1, 1'b0);
    chk("R5 cout a", cout_a, m_sr[0][0]);
    check_dev("R5 idle clocks");
    read_loop("R6 R5 read");
    read_loop("R6 second read");

    // R9: short transaction loaded as shifted
    sel_hi();
    bit_out(1'b1, 1'b1);
    bit_out(1'b0, 1'b1);
    bit_out(1'b1, 1'b1);
    bit_out(1'b1, 1'b1);
    bit_out(1'b0, 1'b1);
    sel_lo();
    model_load();
    check_dev("R9 short");

    // R10: clock rise and select fall in the same sample
    sel_hi();
    send_dev(8'hC3, 8'h3C, 1'b1);
    din_drv = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b1;
    ser_sel = 1'b0;
    repeat (8) @(negedge clk);
    ser_clk = 1'b0;
    repeat (4) @(negedge clk);
    model_load();
    check_dev("R10 collide");
    chk("R10 cout a", cout_a, m_sr[0][0]);
    chk("R10 w0 a", w0_a, 8'hC3);
    read_loop("R10 R6 read");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule